// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block runs the memory side of exception entry and exception return for a 32-bit processor with a 16-bit status word. A request carries the exception number, a flag that marks a hardware interrupt, the pending interrupt level, the current program counter, status word, active stack pointer, the other stack pointer and the vector table base. On entry the block builds a frame on the stack through a simple memory write port. It reads the handler address from the vector table. It then presents the new program counter, status word and both stack pointers along with a one-cycle completion pulse.

On return the block reads a frame back, skips the extra words that the frame's format carries, and reports the restored program counter, status word and stack pointers. A hardware interrupt that arrives while the master bit is set produces two frames on two stacks. A return that meets a format 1 frame moves to the other stack and continues unwinding there.

Top module: `exc_frame_seq`

## Requirements
- R1: An entry request with `hw_irq` high is taken only when `irq_level` is strictly greater than the mask field `cur_sr[10:8]`. Otherwise it starts no memory traffic and gives no `done`. Any request that arrives while `busy` is high has no effect.
- R2: Entry pushes go downward from `cur_sp` with bit 0 cleared. The order is the format's extra long(s), the format/vector word, the 32-bit return PC, and last the old status word. `new_sp` is the address of that last write.
- R3: The format/vector word equals format×4096 + exception number×4.
- R4: Exception 3 uses format 2 with extra long 0. Exceptions 4, 5, 6, 7 and 9 use format 2 with `cur_pc` as the extra long. Every other exception uses format 0, which has no extra long.
- R5: For a software request with exception number 32 to 47, the stacked return PC is `cur_pc`+2. In every other case it is `cur_pc`.
- R6: The entry status result has bit 13 (supervisor) set and bit 15 (trace) clear. For a hardware interrupt, bits 10:8 hold `irq_level`. All other bits are copied from `cur_sr`.
- R7: A hardware interrupt with exception number 24 to 31 and `cur_sr[12]` (master) set first pushes a format 0 frame with the old status on the current stack. It then pushes a format 1 frame on `alt_sp` (bit 0 cleared) holding the new status with bit 12 still set. The final status has bit 12 clear, and `new_alt_sp` is the current stack after the first frame.
- R8: After the pushes, one long read at `vec_base` + exception×4 gives `new_pc`. `done` is high for exactly one cycle, and the outputs are valid in that cycle.
- R9: A return reads a word at SP (status), a long at SP+2 (PC) and a word at SP+6 (format in bits 15:12). The final SP is SP+8 plus 4 for formats 2 and 3, plus 8 for format 4, plus 52 for format 7, and plus 0 for all other formats. A return never writes.
- R10: On a format 1 frame the return continues at `alt_sp`, and `new_alt_sp` becomes the SP just past the format 1 frame. The status and PC reported are those of the last frame read.
- R11: Each push or pop is one transfer. `mem_req` stays high with a stable address until `mem_ack`. `mem_long` selects 32 bits over 16, and word data travels in bits 15:0 of the data buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Start exception entry |
| return_req | input | 1 | Start exception return |
| exc_num | input | 8 | Exception number |
| hw_irq | input | 1 | Request is a hardware interrupt |
| irq_level | input | 3 | Pending interrupt level |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| cur_sp | input | 32 | Active stack pointer |
| alt_sp | input | 32 | Other stack pointer |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_long | output | 1 | 1: 32-bit transfer, 0: 16-bit |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer complete |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler or restored PC |
| new_sr | output | 16 | Resulting status word |
| new_sp | output | 32 | Resulting active stack pointer |
| new_alt_sp | output | 32 | Resulting other stack pointer |

## Verification
Most internal faults in this block show at the memory port first. A wrong stack pointer, format or state step changes the address, size or data of the very next transfer, and the scoreboard compares every transfer as it is acknowledged. So a bad SP update is seen within one transfer, one or two cycles later. Faults in the final status or in the stack swap stay hidden until `done`, where the four result ports are compared. The throwaway path and the format 1 unwind are the only places where `new_alt_sp` differs from `alt_sp`. A request that should be ignored would show as an unexpected transfer or an unexpected `done`.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;

  localparam int VEC_W = 8;
  typedef logic [VEC_W-1:0] vec_t;

  // status word bit positions
  localparam int SR_TRACE = 15;
  localparam int SR_SUPER = 13;
  localparam int SR_MSTR  = 12;
  localparam int SR_IM_LO = 8;

  // exception numbers that steer frame selection
  localparam vec_t EX_ADDR_ERR = vec_t'(3);
  localparam vec_t EX_ILLEGAL  = vec_t'(4);
  localparam vec_t EX_DIVZERO  = vec_t'(5);
  localparam vec_t EX_BOUNDS   = vec_t'(6);
  localparam vec_t EX_CONDTRAP = vec_t'(7);
  localparam vec_t EX_TRACE    = vec_t'(9);
  localparam vec_t EX_IRQ_LO   = vec_t'(24);
  localparam vec_t EX_IRQ_HI   = vec_t'(31);
  localparam vec_t EX_TRAP_LO  = vec_t'(32);
  localparam vec_t EX_TRAP_HI  = vec_t'(47);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_X, ST_PUSH_FV, ST_PUSH_PC, ST_PUSH_SR,
    ST_VEC, ST_POP_SR, ST_POP_PC, ST_POP_FV, ST_DONE
  } seq_state_e;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_frame_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  vec_t              exc_i,
  input  logic              hw_i,
  input  logic [2:0]        level_i,
  input  logic [2:0]        mask_i,
  input  logic              mstr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [3:0]        fmt_o,
  output logic [ADDR_W-1:0] xaddr_o,
  output logic [ADDR_W-1:0] retpc_o,
  output logic              throw_o,
  output logic              accept_o
);
  logic is_trap;

  always_comb begin
    fmt_o   = 4'd0;
    xaddr_o = '0;
    if (exc_i == EX_ADDR_ERR) begin
      fmt_o = 4'd2;
    end else if (exc_i inside {EX_ILLEGAL, EX_DIVZERO, EX_BOUNDS, EX_CONDTRAP, EX_TRACE}) begin
      fmt_o   = 4'd2;
      xaddr_o = pc_i;
    end
  end

  assign is_trap  = !hw_i && (exc_i >= EX_TRAP_LO) && (exc_i <= EX_TRAP_HI);
  assign retpc_o  = is_trap ? pc_i + ADDR_W'(2) : pc_i;
  assign throw_o  = hw_i && mstr_i && (exc_i >= EX_IRQ_LO) && (exc_i <= EX_IRQ_HI);
  assign accept_o = !hw_i || (level_i > mask_i);

endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_frame_pkg::*;
(
  input  logic [15:0] sr_i,
  input  logic        hw_i,
  input  logic [2:0]  level_i,
  output logic [15:0] sr_o
);
  always_comb begin
    sr_o           = sr_i;
    sr_o[SR_SUPER] = 1'b1;
    sr_o[SR_TRACE] = 1'b0;
    if (hw_i) sr_o[SR_IM_LO +: 3] = level_i;
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic              return_req,
  input  logic [VEC_W-1:0]  exc_num,
  input  logic              hw_irq,
  input  logic [2:0]        irq_level,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [15:0]       cur_sr,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] alt_sp,
  input  logic [ADDR_W-1:0] vec_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_long,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] new_pc,
  output logic [15:0]       new_sr,
  output logic [ADDR_W-1:0] new_sp,
  output logic [ADDR_W-1:0] new_alt_sp
);
  localparam logic [ADDR_W-1:0] EVEN_MASK = ~ADDR_W'(1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] sp_q, sp_d, oth_q, oth_d, pc_q, pc_d;
  logic [ADDR_W-1:0] xaddr_q, xaddr_d, vbase_q, vbase_d;
  logic [15:0]       sr_q, sr_d, stk_q, stk_d;
  logic [3:0]        fmt_q, fmt_d;
  vec_t              vec_q, vec_d;
  logic              throw_q, throw_d, entry_q, entry_d;
  logic              xfer, dp_en;
  logic [15:0]       fv_word;
  logic [ADDR_W-1:0] pop_base, pop_skip;

  logic [3:0]        c_fmt;
  logic [ADDR_W-1:0] c_xaddr, c_retpc;
  logic              c_throw, c_accept;
  logic [15:0]       c_sr;

  exc_classify #(.ADDR_W(ADDR_W)) u_class (
    .exc_i(exc_num), .hw_i(hw_irq), .level_i(irq_level),
    .mask_i(cur_sr[SR_IM_LO +: 3]), .mstr_i(cur_sr[SR_MSTR]), .pc_i(cur_pc),
    .fmt_o(c_fmt), .xaddr_o(c_xaddr), .retpc_o(c_retpc),
    .throw_o(c_throw), .accept_o(c_accept)
  );

  exc_sr_update u_srup (
    .sr_i(cur_sr), .hw_i(hw_irq), .level_i(irq_level), .sr_o(c_sr)
  );

  assign xfer     = mem_req & mem_ack;
  assign dp_en    = (state_q == ST_IDLE) | xfer;
  assign fv_word  = {fmt_q, 12'h000} + 16'({vec_q, 2'b00});
  assign pop_base = sp_q + ADDR_W'(8);

  always_comb begin
    unique case (mem_rdata[15:12])
      4'd2, 4'd3: pop_skip = ADDR_W'(4);
      4'd4:       pop_skip = ADDR_W'(8);
      4'd7:       pop_skip = ADDR_W'(52);
      default:    pop_skip = '0;
    endcase
  end

  // memory port decode
  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_long  = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_X:  begin mem_we = 1'b1; mem_long = 1'b1; mem_addr = sp_q - ADDR_W'(4); mem_wdata = 32'(xaddr_q); end
      ST_PUSH_FV: begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(2); mem_wdata = {16'h0000, fv_word}; end
      ST_PUSH_PC: begin mem_we = 1'b1; mem_long = 1'b1; mem_addr = sp_q - ADDR_W'(4); mem_wdata = 32'(pc_q); end
      ST_PUSH_SR: begin mem_we = 1'b1; mem_addr = sp_q - ADDR_W'(2); mem_wdata = {16'h0000, stk_q}; end
      ST_VEC:     begin mem_long = 1'b1; mem_addr = vbase_q + ADDR_W'({vec_q, 2'b00}); end
      ST_POP_SR:  mem_addr = sp_q;
      ST_POP_PC:  begin mem_long = 1'b1; mem_addr = sp_q + ADDR_W'(2); end
      ST_POP_FV:  mem_addr = sp_q + ADDR_W'(6);
      default:    mem_req = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q; sp_d = sp_q; oth_d = oth_q; pc_d = pc_q;
    xaddr_d = xaddr_q; vbase_d = vbase_q; sr_d = sr_q; stk_d = stk_q;
    fmt_d = fmt_q; vec_d = vec_q; throw_d = throw_q; entry_d = entry_q;
    unique case (state_q)
      ST_IDLE: begin
        if (entry_req) begin
          if (c_accept) begin
            sp_d = cur_sp & EVEN_MASK; oth_d = alt_sp; pc_d = c_retpc;
            xaddr_d = c_xaddr; vbase_d = vec_base; sr_d = c_sr; stk_d = cur_sr;
            fmt_d = c_fmt; vec_d = exc_num; throw_d = c_throw; entry_d = 1'b1;
            state_d = (c_fmt == 4'd2) ? ST_PUSH_X : ST_PUSH_FV;
          end
        end else if (return_req) begin
          sp_d = cur_sp; oth_d = alt_sp; entry_d = 1'b0; throw_d = 1'b0;
          state_d = ST_POP_SR;
        end
      end
      ST_PUSH_X:  if (xfer) begin sp_d = sp_q - ADDR_W'(4); state_d = ST_PUSH_FV; end
      ST_PUSH_FV: if (xfer) begin sp_d = sp_q - ADDR_W'(2); state_d = ST_PUSH_PC; end
      ST_PUSH_PC: if (xfer) begin sp_d = sp_q - ADDR_W'(4); state_d = ST_PUSH_SR; end
      ST_PUSH_SR: if (xfer) begin
        if (throw_q) begin
          throw_d = 1'b0; fmt_d = 4'd1; stk_d = sr_q;
          sr_d = sr_q; sr_d[SR_MSTR] = 1'b0;
          sp_d = oth_q & EVEN_MASK; oth_d = sp_q - ADDR_W'(2);
          state_d = ST_PUSH_FV;
        end else begin
          sp_d = sp_q - ADDR_W'(2); state_d = ST_VEC;
        end
      end
      ST_VEC:    if (xfer) begin pc_d = ADDR_W'(mem_rdata); state_d = ST_DONE; end
      ST_POP_SR: if (xfer) begin sr_d = mem_rdata[15:0]; state_d = ST_POP_PC; end
      ST_POP_PC: if (xfer) begin pc_d = ADDR_W'(mem_rdata); state_d = ST_POP_FV; end
      ST_POP_FV: if (xfer) begin
        if (mem_rdata[15:12] == 4'd1) begin
          sp_d = oth_q; oth_d = pop_base; state_d = ST_POP_SR;
        end else begin
          sp_d = pop_base + pop_skip; state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0; oth_q <= '0; pc_q <= '0; xaddr_q <= '0; vbase_q <= '0;
      sr_q <= '0; stk_q <= '0; fmt_q <= '0; vec_q <= '0;
      throw_q <= 1'b0; entry_q <= 1'b0;
    end else if (dp_en) begin
      sp_q <= sp_d; oth_q <= oth_d; pc_q <= pc_d; xaddr_q <= xaddr_d; vbase_q <= vbase_d;
      sr_q <= sr_d; stk_q <= stk_d; fmt_q <= fmt_d; vec_q <= vec_d;
      throw_q <= throw_d; entry_q <= entry_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign new_pc     = pc_q;
  assign new_sr     = sr_q;
  assign new_sp     = sp_q;
  assign new_alt_sp = oth_q;

  // R11: request held with a stable address until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: a return sequence never writes memory
  p_return_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !entry_q |-> !mem_we);
  // R6: entry result is supervisor with trace off
  p_entry_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && entry_q |-> new_sr[SR_SUPER] && !new_sr[SR_TRACE]);
  // R2: frames built on entry end on an even address
  p_entry_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && entry_q |-> !new_sp[0]);

endmodule

// File: tb/exc_frame_seq_test.sv
`timescale 1ns/1ps
module exc_frame_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        entry_req, return_req, hw_irq;
  logic [7:0]  exc_num;
  logic [2:0]  irq_level;
  logic [31:0] cur_pc, cur_sp, alt_sp, vec_base;
  logic [15:0] cur_sr;
  logic        mem_req, mem_we, mem_long, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done;
  logic [31:0] new_pc, new_sp, new_alt_sp;
  logic [15:0] new_sr;

  always #2.5 clk = ~clk;

  exc_frame_seq uut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .return_req(return_req),
    .exc_num(exc_num), .hw_irq(hw_irq), .irq_level(irq_level), .cur_pc(cur_pc),
    .cur_sr(cur_sr), .cur_sp(cur_sp), .alt_sp(alt_sp), .vec_base(vec_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .new_pc(new_pc), .new_sr(new_sr),
    .new_sp(new_sp), .new_alt_sp(new_alt_sp)
  );

  typedef struct {
    bit          we;
    bit          lng;
    logic [31:0] addr;
    logic [31:0] data;
  } txn_t;

  txn_t  expq[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R11";
  bit    slow    = 1'b0;
  bit    stalled = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input bit we, input bit lng, input logic [31:0] a, input logic [31:0] d);
    txn_t t;
    t.we = we; t.lng = lng; t.addr = a; t.data = d;
    expq.push_back(t);
  endtask

  // memory responder and scoreboard monitor
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (slow && !stalled) stalled = 1'b1;
        else begin
          stalled = 1'b0;
          if (expq.size() == 0) begin
            check(1'b0, cur_tag, "unexpected transfer addr", mem_addr, 32'h0);
            mem_rdata = '0;
          end else begin
            txn_t t;
            t = expq.pop_front();
            check(mem_we == t.we, cur_tag, "transfer direction", 32'(mem_we), 32'(t.we));
            check(mem_long == t.lng, "R11", "transfer size", 32'(mem_long), 32'(t.lng));
            check(mem_addr == t.addr, cur_tag, "transfer address", mem_addr, t.addr);
            if (t.we) check(mem_wdata == t.data, cur_tag, "write data", mem_wdata, t.data);
            mem_rdata = t.we ? 32'h0 : t.data;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic exp_frame(input logic [3:0] fmt, input logic [7:0] exc, input logic [15:0] sr,
                           input logic [31:0] rpc, input bit hasx, input logic [31:0] xa,
                           inout logic [31:0] sp);
    logic [15:0] fv;
    fv = (16'(fmt) << 12) + 16'(exc) * 16'd4;   // R3
    if (hasx) begin sp = sp - 4; push_exp(1, 1, sp, xa); end
    sp = sp - 2; push_exp(1, 0, sp, {16'h0, fv});
    sp = sp - 4; push_exp(1, 1, sp, rpc);
    sp = sp - 2; push_exp(1, 0, sp, {16'h0, sr});
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    check(done == 1'b1, tag, "done pulse seen", 32'(done), 32'h1);
  endtask

  task automatic run_entry(input string tag, input logic [7:0] exc, input bit hw,
                           input logic [2:0] lvl, input logic [31:0] pc, input logic [15:0] sr,
                           input logic [31:0] sp, input logic [31:0] alt,
                           input logic [31:0] vb, input logic [31:0] handler, input bit poke);
    logic [3:0]  fmt = 4'd0;
    bit          hasx = 0;
    logic [31:0] xa = 0, rpc, s, oth;
    logic [15:0] nsr;
    cur_tag = tag;
    if (exc == 8'd3) begin fmt = 2; hasx = 1; xa = 0; end                        // R4
    else if (exc inside {8'd4, 8'd5, 8'd6, 8'd7, 8'd9}) begin fmt = 2; hasx = 1; xa = pc; end
    rpc = (!hw && exc >= 8'd32 && exc <= 8'd47) ? pc + 2 : pc;                      // R5
    nsr = sr | 16'h2000; nsr[15] = 1'b0;                                            // R6
    if (hw) nsr[10:8] = lvl;
    s = sp & ~32'h1; oth = alt;
    if (hw && sr[12] && exc >= 8'd24 && exc <= 8'd31) begin                         // R7
      exp_frame(4'd0, exc, sr, rpc, 0, 0, s);
      oth = s;
      s = alt & ~32'h1;
      exp_frame(4'd1, exc, nsr, rpc, 0, 0, s);
      nsr[12] = 1'b0;
    end else exp_frame(fmt, exc, sr, rpc, hasx, xa, s);
    push_exp(0, 1, vb + 32'(exc) * 4, handler);                                     // R8
    @(negedge clk);
    exc_num = exc; hw_irq = hw; irq_level = lvl; cur_pc = pc; cur_sr = sr;
    cur_sp = sp; alt_sp = alt; vec_base = vb; entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    if (poke) begin
      // R1: requests while busy must not disturb the running sequence
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R1", "busy during sequence", 32'(busy), 32'h1);
      return_req = 1'b1; entry_req = 1'b1; exc_num = 8'd70;
      @(negedge clk);
      return_req = 1'b0; entry_req = 1'b0; exc_num = exc;
    end
    wait_done(tag);
    check(new_pc == handler, "R8", "new_pc", new_pc, handler);
    check(new_sr == nsr, tag, "new_sr", 32'(new_sr), 32'(nsr));
    check(new_sp == s, tag, "new_sp", new_sp, s);
    check(new_alt_sp == oth, tag, "new_alt_sp", new_alt_sp, oth);
    @(negedge clk);
    check(done == 1'b0, "R8", "done after pulse", 32'(done), 32'h0);
    check(expq.size() == 0, tag, "pending expected transfers", 32'(expq.size()), 32'h0);
    expq.delete();
  endtask

  function automatic logic [31:0] skip_of(input logic [3:0] f);
    case (f)
      4'd2, 4'd3: return 32'd4;
      4'd4:       return 32'd8;
      4'd7:       return 32'd52;
      default:    return 32'd0;
    endcase
  endfunction

  task automatic run_return(input string tag, input logic [31:0] sp, input logic [31:0] alt,
                            input logic [3:0] fa, input logic [15:0] sra, input logic [31:0] pca,
                            input logic [3:0] fb, input logic [15:0] srb, input logic [31:0] pcb);
    logic [31:0] s, oth, epc;
    logic [15:0] esr;
    cur_tag = tag;
    push_exp(0, 0, sp, {16'h0, sra});
    push_exp(0, 1, sp + 2, pca);
    push_exp(0, 0, sp + 6, {16'h0, fa, 12'h0A8});
    if (fa == 4'd1) begin                                                           // R10
      oth = sp + 8; s = alt;
      push_exp(0, 0, s, {16'h0, srb});
      push_exp(0, 1, s + 2, pcb);
      push_exp(0, 0, s + 6, {16'h0, fb, 12'h064});
      s = s + 8 + skip_of(fb); esr = srb; epc = pcb;
    end else begin
      s = sp + 8 + skip_of(fa); oth = alt; esr = sra; epc = pca;
    end
    @(negedge clk);
    cur_sp = sp; alt_sp = alt; return_req = 1'b1;
    @(negedge clk);
    return_req = 1'b0;
    wait_done(tag);
    check(new_pc == epc, tag, "restored pc", new_pc, epc);
    check(new_sr == esr, tag, "restored sr", 32'(new_sr), 32'(esr));
    check(new_sp == s, tag, "restored sp", new_sp, s);
    check(new_alt_sp == oth, tag, "restored alt sp", new_alt_sp, oth);
    @(negedge clk);
    check(expq.size() == 0, tag, "pending expected transfers", 32'(expq.size()), 32'h0);
    expq.delete();
  endtask

  task automatic ignored_irq(input logic [2:0] lvl, input logic [15:0] sr);
    bit bad = 0;
    cur_tag = "R1";
    @(negedge clk);
    exc_num = 8'd26; hw_irq = 1'b1; irq_level = lvl; cur_sr = sr; entry_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    repeat (8) begin
      if (busy || done || mem_req) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R1", "masked interrupt ignored", 32'(bad), 32'h0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; entry_req = 0; return_req = 0; hw_irq = 0; exc_num = 0;
    irq_level = 0; cur_pc = 0; cur_sr = 0; cur_sp = 0; alt_sp = 0; vec_base = 0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R8", "idle in reset", {busy, done}, 32'h0);
    check(mem_req == 1'b0, "R11", "no request in reset", 32'(mem_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", {busy, mem_req}, 32'h0);

    // format 0 frames, R2 R3
    run_entry("R2", 8'd64, 0, 3'd0, 32'h0000_1000, 16'h0700, 32'h0000_8000, 32'h0000_4000, 32'h0, 32'h0000_2400, 0);
    run_entry("R2", 8'd8,  0, 3'd0, 32'h0000_1234, 16'h2004, 32'h0000_7FFF, 32'h0000_4000, 32'h0010_0000, 32'h00AB_CD00, 0);
    run_entry("R3", 8'd255, 0, 3'd0, 32'h0000_2000, 16'h0000, 32'h0000_6000, 32'h0000_4000, 32'h0010_0000, 32'h1234_5678, 0);
    // traps, R5
    run_entry("R5", 8'd37, 0, 3'd0, 32'h0000_3000, 16'h0000, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_5000, 0);
    run_entry("R5", 8'd32, 0, 3'd0, 32'h0000_3100, 16'h0000, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_5000, 0);
    run_entry("R5", 8'd47, 0, 3'd0, 32'h0000_3200, 16'h0000, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_5000, 0);
    run_entry("R5", 8'd48, 0, 3'd0, 32'h0000_3300, 16'h0000, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_5000, 0);
    run_entry("R5", 8'd33, 1, 3'd6, 32'h0000_3400, 16'h0300, 32'h0000_8000, 32'h0, 32'h0, 32'h0000_5000, 0);
    // format 2, R4
    slow = 1'b1;
    run_entry("R4", 8'd3, 0, 3'd0, 32'h0000_4440, 16'h0000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    run_entry("R4", 8'd4, 0, 3'd0, 32'h0000_4444, 16'h8000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    run_entry("R4", 8'd5, 0, 3'd0, 32'h0000_4448, 16'h0000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    slow = 1'b0;
    run_entry("R4", 8'd6, 0, 3'd0, 32'h0000_444C, 16'h0000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    run_entry("R4", 8'd7, 0, 3'd0, 32'h0000_4450, 16'h0000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    run_entry("R4", 8'd9, 0, 3'd0, 32'h0000_4454, 16'h0000, 32'h0000_9000, 32'h0, 32'h0, 32'h0000_6000, 0);
    // interrupts, R6 R1
    run_entry("R6", 8'd29, 1, 3'd5, 32'h0000_5000, 16'h2200, 32'h0000_A000, 32'h0000_4000, 32'h0, 32'h0000_7000, 0);
    run_entry("R6", 8'd25, 1, 3'd1, 32'h0000_5010, 16'h8000, 32'h0000_A000, 32'h0000_4000, 32'h0, 32'h0000_7000, 0);
    ignored_irq(3'd4, 16'h0400);
    ignored_irq(3'd3, 16'h0500);
    ignored_irq(3'd7, 16'h0700);
    // throwaway frames, R7
    run_entry("R7", 8'd27, 1, 3'd3, 32'h0000_6000, 16'h3000, 32'h0000_9000, 32'h0000_4000, 32'h0, 32'h0000_8800, 0);
    slow = 1'b1;
    run_entry("R7", 8'd24, 1, 3'd1, 32'h0000_6100, 16'hB000, 32'h0000_9001, 32'h0000_4003, 32'h0010_0000, 32'h0000_8900, 0);
    slow = 1'b0;
    run_entry("R7", 8'd64, 1, 3'd6, 32'h0000_6200, 16'h3000, 32'h0000_9000, 32'h0000_4000, 32'h0, 32'h0000_8A00, 0);
    // busy ignore, R1
    slow = 1'b1;
    run_entry("R1", 8'd70, 0, 3'd0, 32'h0000_7000, 16'h0000, 32'h0000_8000, 32'h0000_4000, 32'h0, 32'h0000_9900, 1);
    slow = 1'b0;
    // returns, R9 R10
    run_return("R9", 32'h0000_7FF8, 32'h0000_4000, 4'd0, 16'h0004, 32'h0000_1000, 4'd0, 16'h0, 32'h0);
    run_return("R9", 32'h0000_7FF0, 32'h0000_4000, 4'd2, 16'h2700, 32'h0000_1100, 4'd0, 16'h0, 32'h0);
    run_return("R9", 32'h0000_7FF0, 32'h0000_4000, 4'd3, 16'h0010, 32'h0000_1200, 4'd0, 16'h0, 32'h0);
    run_return("R9", 32'h0000_7FE0, 32'h0000_4000, 4'd4, 16'h0011, 32'h0000_1300, 4'd0, 16'h0, 32'h0);
    run_return("R9", 32'h0000_7F00, 32'h0000_4000, 4'd7, 16'h0012, 32'h0000_1400, 4'd0, 16'h0, 32'h0);
    run_return("R9", 32'h0000_7F00, 32'h0000_4000, 4'd5, 16'h0013, 32'h0000_1500, 4'd0, 16'h0, 32'h0);
    run_return("R10", 32'h0000_3FF8, 32'h0000_8FF8, 4'd1, 16'h3400, 32'h0000_1600, 4'd0, 16'h3000, 32'h0000_1700);
    slow = 1'b1;
    run_return("R10", 32'h0000_3FF8, 32'h0000_8FF4, 4'd1, 16'h3400, 32'h0000_1800, 4'd2, 16'h2100, 32'h0000_1900);
    slow = 1'b0;

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule